// File: doc/BRIEF.md
# MESI Snooping Line State Controller

This block keeps the coherence state of a small, fully associative set of cache lines for one processor on a shared snooping bus. Each entry holds an address tag and a two-bit state: Invalid, Shared, Exclusive or Modified. Local reads and writes are looked up against the entries. A hit that needs no bus traffic completes on the next cycle. A miss, or a write to a Shared line, raises a bus command and waits for a grant. The bus "shared" response, sampled with the grant, tells a read fill whether it lands as Exclusive or Shared.

On the other side, the block watches reads and write-intent requests that other processors put on the bus. A hit on such a snoop changes the line state on the next edge. In the same cycle the snoop is presented, the block drives a shared-response output and a flush output, which tells the bus that this cache holds dirty data that must be written back. Data movement is not modelled: the block only issues the commands and handshake pulses that a data path would act on.

A miss takes the lowest Invalid entry. When every entry is valid, a round-robin pointer picks the victim. Evicting a Modified victim raises a one-cycle writeback request that carries the victim's tag. Evicting a clean victim is silent.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every entry is Invalid, `cpu_ready` is 1, `bus_req_valid`, `wb_req_valid` and `cpu_done` are 0, and a snoop of any tag gets no shared response.
- R2: A local read miss raises `bus_req_cmd`=1 (read). On the grant edge the line fills as Exclusive (state code 2) if `bus_shared_in` is 0, or as Shared (code 1) if it is 1. `cpu_done` pulses on the cycle after the grant, with `cpu_state` giving the filled state.
- R3: A local write miss raises `bus_req_cmd`=2 (read-for-ownership) and the line fills as Modified (code 3).
- R4: A local write that hits an Exclusive line makes it Modified. `cpu_done` pulses on the next cycle and no bus request is made.
- R5: A local write that hits a Shared line raises `bus_req_cmd`=3 (upgrade) and the line becomes Modified on the grant. If a snooped write-intent invalidates that line while the request waits, the command changes to 2 before the grant.
- R6: A snooped read (`snoop_write`=0) that hits a valid line drives `snoop_shared` high in the same cycle. An Exclusive line then becomes Shared, and a Shared line stays Shared.
- R7: A snooped read that hits a Modified line drives `snoop_flush` high in the same cycle, and the line becomes Shared.
- R8: A snooped write-intent (`snoop_write`=1) that hits a line makes it Invalid. `snoop_flush` is high only when that line was Modified.
- R9: A miss fills the lowest Invalid entry. When all entries are valid, victims are taken in round-robin order starting at entry 0. A Modified victim produces a one-cycle `wb_req_valid` pulse with its tag, on the cycle the miss request appears. A clean victim produces no pulse.
- R10: A read hit in any valid state, or a write hit on a Modified line, pulses `cpu_done` on the next cycle with the unchanged state and makes no bus request.
- R11: `cpu_ready` is 0 while `snoop_valid` is 1 and while a bus request is outstanding. A request is taken only when `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Local access request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_tag | input | TAG_W | Line tag of the local access |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| cpu_done | output | 1 | One-cycle pulse: local access complete |
| cpu_state | output | 2 | Line state after the completed access (0 I, 1 S, 2 E, 3 M) |
| bus_req_valid | output | 1 | Bus command pending |
| bus_req_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 upgrade |
| bus_req_tag | output | TAG_W | Tag of the pending bus command |
| bus_gnt | input | 1 | Grant of the pending bus command |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with grant) |
| wb_req_valid | output | 1 | Writeback request for an evicted Modified line |
| wb_req_tag | output | TAG_W | Tag of the evicted line |
| snoop_valid | input | 1 | Snooped request from another processor |
| snoop_write | input | 1 | 1 = write intent, 0 = read |
| snoop_tag | input | TAG_W | Tag of the snooped request |
| snoop_shared | output | 1 | Shared response for a snooped read |
| snoop_flush | output | 1 | Snooped line is Modified here and must be written back |

## Verification
The assertions assume that the bus grants only a pending request and that it never presents a snoop on the same edge as a grant to the same line. They also assume `bus_shared_in` is meaningful only together with the grant. The directed stimulus respects all of this. It raises `bus_gnt` for exactly one cycle, and only after it has seen `bus_req_valid`. Snoops come either between accesses or during a wait cycle that has no grant. Each local request is held for a single accepted edge and then dropped.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_t;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_WAIT = 1'b1
    } ctrl_fsm_t;

    // State a line takes after a snoop hit.
    function automatic line_st_t snoop_next(line_st_t cur, logic wr_intent);
        if (cur == ST_I || wr_intent) return ST_I;
        return ST_S;
    endfunction

    // State a line takes when its bus command is granted.
    function automatic line_st_t fill_state(bus_cmd_t cmd, logic shared_in);
        if (cmd == CMD_RD) return shared_in ? ST_S : ST_E;
        return ST_M;
    endfunction

endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [DEPTH-1:0]            valid,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mesi_victim_pick.sv
module mesi_victim_pick #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] valid,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = ~&valid;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        victim = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance && !any_free) begin
            rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req_valid,
    input  logic             cpu_req_write,
    input  logic [TAG_W-1:0] cpu_req_tag,
    output logic             cpu_ready,
    output logic             cpu_done,
    output logic [1:0]       cpu_state,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_cmd,
    output logic [TAG_W-1:0] bus_req_tag,
    input  logic             bus_gnt,
    input  logic             bus_shared_in,
    output logic             wb_req_valid,
    output logic [TAG_W-1:0] wb_req_tag,
    input  logic             snoop_valid,
    input  logic             snoop_write,
    input  logic [TAG_W-1:0] snoop_tag,
    output logic             snoop_shared,
    output logic             snoop_flush
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][TAG_W-1:0] tag_q;
    line_st_t                    st_q [DEPTH];
    logic [DEPTH-1:0]            valid_vec;

    ctrl_fsm_t        fsm_q;
    bus_cmd_t         cmd_q;
    logic [IDX_W-1:0] pidx_q;
    logic [TAG_W-1:0] ptag_q;
    logic             done_q;
    line_st_t         dstate_q;
    logic             wb_v_q;
    logic [TAG_W-1:0] wb_tag_q;

    logic             c_hit, s_hit;
    logic [IDX_W-1:0] c_idx, s_idx, v_idx;
    line_st_t         c_st, s_st, v_st;
    logic             accept;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) valid_vec[i] = (st_q[i] != ST_I);
    end

    mesi_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cpu_match (
        .tags(tag_q), .valid(valid_vec), .key(cpu_req_tag), .hit(c_hit), .idx(c_idx)
    );

    mesi_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_snp_match (
        .tags(tag_q), .valid(valid_vec), .key(snoop_tag), .hit(s_hit), .idx(s_idx)
    );

    mesi_victim_pick #(.DEPTH(DEPTH)) u_victim (
        .clk(clk), .rst(rst), .valid(valid_vec),
        .advance(accept && !c_hit), .victim(v_idx)
    );

    assign c_st = st_q[c_idx];
    assign s_st = st_q[s_idx];
    assign v_st = st_q[v_idx];

    assign cpu_ready = (fsm_q == FSM_IDLE) && !snoop_valid;
    assign accept    = cpu_ready && cpu_req_valid;

    assign snoop_shared = snoop_valid && !snoop_write && s_hit;
    assign snoop_flush  = snoop_valid && s_hit && (s_st == ST_M);

    assign cpu_done      = done_q;
    assign cpu_state     = dstate_q;
    assign bus_req_valid = (fsm_q == FSM_WAIT);
    assign bus_req_cmd   = cmd_q;
    assign bus_req_tag   = ptag_q;
    assign wb_req_valid  = wb_v_q;
    assign wb_req_tag    = wb_tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_I;
            tag_q    <= '0;
            fsm_q    <= FSM_IDLE;
            cmd_q    <= CMD_NONE;
            pidx_q   <= '0;
            ptag_q   <= '0;
            done_q   <= 1'b0;
            dstate_q <= ST_I;
            wb_v_q   <= 1'b0;
            wb_tag_q <= '0;
        end else begin
            done_q <= 1'b0;
            wb_v_q <= 1'b0;

            // Snoop side: state update on hit.
            if (snoop_valid && s_hit) begin
                st_q[s_idx] <= snoop_next(s_st, snoop_write);
                // A pending upgrade whose line is taken away needs a full fetch.
                if (fsm_q == FSM_WAIT && cmd_q == CMD_UPG && snoop_write && s_idx == pidx_q)
                    cmd_q <= CMD_RDX;
            end

            // Processor side: accept (never on a snoop cycle).
            if (accept) begin
                if (c_hit) begin
                    if (!cpu_req_write || c_st == ST_M) begin
                        done_q   <= 1'b1;
                        dstate_q <= c_st;
                    end else if (c_st == ST_E) begin
                        st_q[c_idx] <= ST_M;
                        done_q      <= 1'b1;
                        dstate_q    <= ST_M;
                    end else begin
                        fsm_q  <= FSM_WAIT;
                        cmd_q  <= CMD_UPG;
                        pidx_q <= c_idx;
                        ptag_q <= cpu_req_tag;
                    end
                end else begin
                    fsm_q         <= FSM_WAIT;
                    cmd_q         <= cpu_req_write ? CMD_RDX : CMD_RD;
                    pidx_q        <= v_idx;
                    ptag_q        <= cpu_req_tag;
                    st_q[v_idx]   <= ST_I;
                    tag_q[v_idx]  <= cpu_req_tag;
                    if (v_st == ST_M) begin
                        wb_v_q   <= 1'b1;
                        wb_tag_q <= tag_q[v_idx];
                    end
                end
            end

            // Grant completes the pending command.
            if (fsm_q == FSM_WAIT && bus_gnt) begin
                st_q[pidx_q] <= fill_state(cmd_q, bus_shared_in);
                fsm_q        <= FSM_IDLE;
                cmd_q        <= CMD_NONE;
                done_q       <= 1'b1;
                dstate_q     <= fill_state(cmd_q, bus_shared_in);
            end
        end
    end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_ready,
    input logic             cpu_done,
    input logic [1:0]       cpu_state,
    input logic             bus_req_valid,
    input logic [1:0]       bus_req_cmd,
    input logic             bus_gnt,
    input logic             bus_shared_in,
    input logic             wb_req_valid,
    input logic             snoop_valid,
    input logic             snoop_write,
    input logic             snoop_shared,
    input logic             snoop_flush
);
    // R2
    rd_fill_state_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_gnt && bus_req_cmd == 2'd1) |=>
            (cpu_done && cpu_state == ($past(bus_shared_in) ? 2'd1 : 2'd2)));

    // R3
    own_fill_state_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_gnt && bus_req_cmd != 2'd1) |=> (cpu_done && cpu_state == 2'd3));

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_gnt) |=> bus_req_valid);

    // R6
    shared_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_shared |-> (snoop_valid && !snoop_write));

    // R8
    flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_flush |-> snoop_valid);

    // R9
    wb_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req_valid |-> (bus_req_valid && bus_req_cmd != 2'd3)) ;

    // R9
    wb_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req_valid |=> !wb_req_valid);

    // R10
    done_valid_state_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> (cpu_state != 2'd0 && !bus_req_valid));

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid || snoop_valid) |-> !cpu_ready);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_state(cpu_state), .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .wb_req_valid(wb_req_valid),
    .snoop_valid(snoop_valid), .snoop_write(snoop_write),
    .snoop_shared(snoop_shared), .snoop_flush(snoop_flush)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
    localparam int TAG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_req_valid = 1'b0;
    logic             cpu_req_write = 1'b0;
    logic [TAG_W-1:0] cpu_req_tag = '0;
    logic             cpu_ready, cpu_done;
    logic [1:0]       cpu_state;
    logic             bus_req_valid;
    logic [1:0]       bus_req_cmd;
    logic [TAG_W-1:0] bus_req_tag;
    logic             bus_gnt = 1'b0;
    logic             bus_shared_in = 1'b0;
    logic             wb_req_valid;
    logic [TAG_W-1:0] wb_req_tag;
    logic             snoop_valid = 1'b0;
    logic             snoop_write = 1'b0;
    logic [TAG_W-1:0] snoop_tag = '0;
    logic             snoop_shared, snoop_flush;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mesi_line_ctrl #(.DEPTH(4), .TAG_W(TAG_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One local access. cmd = 0 for a hit with no bus request.
    task automatic do_access(input bit w, input int tag, input bit shd, input bit mid_snoop,
                             output int cmd, output int cmd2, output int st,
                             output int wb, output int wbt);
        cmd = 0; cmd2 = 0; st = 0; wb = 0; wbt = 0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = w;
        cpu_req_tag   = TAG_W'(tag);
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        @(negedge clk);
        if (cpu_done) begin
            st = int'(cpu_state);
            if (bus_req_valid) cmd = int'(bus_req_cmd);
        end else if (bus_req_valid) begin
            cmd = int'(bus_req_cmd);
            wb  = int'(wb_req_valid);
            wbt = int'(wb_req_tag);
            chk(!cpu_ready, "R11 ready while waiting", int'(cpu_ready), 0);
            if (mid_snoop) begin
                snoop_valid = 1'b1;
                snoop_write = 1'b1;
                snoop_tag   = TAG_W'(tag);
                @(posedge clk);
                #1 snoop_valid = 1'b0;
                @(negedge clk);
            end
            cmd2 = int'(bus_req_cmd);
            bus_gnt = 1'b1;
            bus_shared_in = shd;
            @(posedge clk);
            #1 bus_gnt = 1'b0;
            bus_shared_in = 1'b0;
            @(negedge clk);
            chk(cpu_done == 1'b1, "R2 done after grant", int'(cpu_done), 1);
            st = int'(cpu_state);
        end else begin
            chk(1'b0, "R10 no response to access", 0, 1);
        end
    endtask

    task automatic do_snoop(input bit w, input int tag, output int sh, output int fl, output int rdy);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_write = w;
        snoop_tag   = TAG_W'(tag);
        #1;
        sh = int'(snoop_shared);
        fl = int'(snoop_flush);
        rdy = int'(cpu_ready);
        @(posedge clk);
        #1 snoop_valid = 1'b0;
    endtask

    task automatic t_reset();
        int cmd, cmd2, st, wb, wbt, sh, fl, rdy;
        do_reset();
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
        chk(!bus_req_valid && !wb_req_valid && !cpu_done, "R1 outputs idle",
            int'({bus_req_valid, wb_req_valid, cpu_done}), 0);
        do_snoop(1'b0, 5, sh, fl, rdy);
        chk(sh == 0, "R1 no shared response", sh, 0);
        do_access(1'b0, 5, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 1, "R1 read misses after reset", cmd, 1);
    endtask

    task automatic t_read_miss();
        int cmd, cmd2, st, wb, wbt;
        do_reset();
        do_access(1'b0, 30, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 1 && st == 2, "R2 unshared fill Exclusive", st * 4 + cmd, 2 * 4 + 1);
        do_access(1'b0, 31, 1'b1, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 1 && st == 1, "R2 shared fill Shared", st * 4 + cmd, 1 * 4 + 1);
        do_access(1'b0, 30, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 2, "R10 read hit keeps Exclusive", st * 4 + cmd, 2 * 4);
    endtask

    task automatic t_write_miss();
        int cmd, cmd2, st, wb, wbt;
        do_reset();
        do_access(1'b1, 40, 1'b1, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 2 && st == 3, "R3 write miss own fetch Modified", st * 4 + cmd, 3 * 4 + 2);
        do_access(1'b0, 40, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 3, "R10 read hit Modified", st * 4 + cmd, 3 * 4);
        do_access(1'b1, 40, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 3, "R10 write hit Modified", st * 4 + cmd, 3 * 4);
    endtask

    task automatic t_write_excl();
        int cmd, cmd2, st, wb, wbt;
        do_reset();
        do_access(1'b0, 50, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        do_access(1'b1, 50, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 3, "R4 silent E to M", st * 4 + cmd, 3 * 4);
        do_access(1'b0, 50, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(st == 3, "R4 line stays Modified", st, 3);
    endtask

    task automatic t_upgrade();
        int cmd, cmd2, st, wb, wbt;
        do_reset();
        do_access(1'b0, 21, 1'b1, 1'b0, cmd, cmd2, st, wb, wbt);
        do_access(1'b1, 21, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 3 && st == 3, "R5 upgrade to Modified", st * 4 + cmd, 3 * 4 + 3);
        do_access(1'b0, 20, 1'b1, 1'b0, cmd, cmd2, st, wb, wbt);
        do_access(1'b1, 20, 1'b0, 1'b1, cmd, cmd2, st, wb, wbt);
        chk(cmd == 3 && cmd2 == 2, "R5 upgrade turns own fetch", cmd2, 2);
        chk(st == 3, "R5 line Modified after fetch", st, 3);
    endtask

    task automatic t_snoop_read();
        int cmd, cmd2, st, wb, wbt, sh, fl, rdy;
        do_reset();
        do_access(1'b0, 60, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        do_snoop(1'b0, 60, sh, fl, rdy);
        chk(sh == 1 && fl == 0, "R6 shared response on E", sh * 2 + fl, 2);
        chk(rdy == 0, "R11 not ready during snoop", rdy, 0);
        do_access(1'b0, 60, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 1, "R6 E becomes Shared", st * 4 + cmd, 4);
        do_access(1'b1, 61, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        do_snoop(1'b0, 61, sh, fl, rdy);
        chk(sh == 1 && fl == 1, "R7 flush on Modified read", sh * 2 + fl, 3);
        do_access(1'b0, 61, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0 && st == 1, "R7 M becomes Shared", st * 4 + cmd, 4);
        do_snoop(1'b0, 99, sh, fl, rdy);
        chk(sh == 0 && fl == 0, "R6 no response on absent line", sh * 2 + fl, 0);
    endtask

    task automatic t_snoop_write();
        int cmd, cmd2, st, wb, wbt, sh, fl, rdy;
        do_reset();
        do_access(1'b0, 70, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        do_access(1'b0, 71, 1'b1, 1'b0, cmd, cmd2, st, wb, wbt);
        do_access(1'b1, 72, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        do_snoop(1'b1, 70, sh, fl, rdy);
        chk(fl == 0 && sh == 0, "R8 E invalidated no flush", sh * 2 + fl, 0);
        do_snoop(1'b1, 71, sh, fl, rdy);
        chk(fl == 0, "R8 S invalidated no flush", fl, 0);
        do_snoop(1'b1, 72, sh, fl, rdy);
        chk(fl == 1, "R8 M invalidated with flush", fl, 1);
        for (int t = 70; t <= 72; t++) begin
            do_access(1'b0, t, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
            chk(cmd == 1, "R8 line now Invalid misses", cmd, 1);
        end
    endtask

    task automatic t_evict();
        int cmd, cmd2, st, wb, wbt;
        do_reset();
        do_access(1'b1, 10, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        for (int t = 11; t <= 13; t++) begin
            do_access(1'b0, t, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
            chk(wb == 0, "R9 fill into free entry silent", wb, 0);
        end
        do_access(1'b0, 12, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0, "R9 full array still hits", cmd, 0);
        do_access(1'b0, 14, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(wb == 1 && wbt == 10, "R9 Modified victim written back", wbt, 10);
        do_access(1'b0, 15, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(wb == 0, "R9 clean victim silent", wb, 0);
        do_access(1'b0, 13, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 0, "R9 entry 3 kept", cmd, 0);
        do_access(1'b0, 11, 1'b0, 1'b0, cmd, cmd2, st, wb, wbt);
        chk(cmd == 1, "R9 round-robin evicted entry 1", cmd, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_read_miss();
        t_write_miss();
        t_write_excl();
        t_upgrade();
        t_snoop_read();
        t_snoop_write();
        t_evict();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule